// File: doc/BRIEF.md
# Serial FIFO Trigger Controller

This block sits behind a serial port and owns two byte queues of sixteen entries each, one feeding the transmitter and one filled by the receiver. It keeps the occupancy of each queue and raises two level flags. The receive flag says enough bytes have arrived. The transmit flag says enough slots are free for software to refill. A single 8-bit control register sets both thresholds from fixed two-bit codes. The same register holds a flush bit for each queue, a modem-control enable and a loopback enable. The last two are only exported to the surrounding port logic.

Software may read or write the control register in any cycle. The serial side pushes received bytes and pops bytes to transmit through single-cycle strobes. Each queue also reports its count (0 to 16) and two sticky error bits. One records a push refused because the queue was full. The other records a pop refused because the queue was empty.

Top module: `sft_trigger_ctrl`

## Requirements
- R1: After reset the control register reads 0x00. A write stores all eight bits, and the new value is visible on `reg_rdata` after the write clock edge.
- R2: While `stby` is high the control register is cleared to 0x00 at each clock edge. This takes priority over a write in the same cycle.
- R3: Each queue returns bytes in the order they were pushed. Popped data appears on its read-data port after the pop edge. The count output tracks occupancy from 0 to 16. A push and a pop in the same cycle on a queue that is neither empty nor full leave the count unchanged.
- R4: The receive flag `rx_full_flag` is 1 exactly when the receive count is at least the level picked by bits 7:6. The codes are 00=1, 01=4, 10=8 and 11=14.
- R5: The transmit flag `tx_room_flag` is 1 exactly when the free slots (16 minus the transmit count) are at least the number picked by bits 5:4. The codes are 00=8, 01=12, 10=14 and 11=15. After reset the flag is 1.
- R6: Both flags follow the count and the control register that are current after the same clock edge. A write to a threshold field therefore changes the flag at the edge of the write.
- R7: Bit 2 flushes the transmit queue and bit 1 flushes the receive queue. While the bit is 1, that queue reads a count of 0, its pushes and pops are ignored, and its sticky error bits are cleared. The other queue is unaffected. Normal operation resumes after the bit is written back to 0.
- R8: A push to a full queue stores nothing, leaves the count at 16 and sets that queue's sticky overflow bit.
- R9: A pop from an empty queue leaves the count at 0 and sets that queue's sticky underflow bit.
- R10: `loopback_en` mirrors control bit 0 and `modem_ctl_en` mirrors control bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stby | input | 1 | Standby; clears the control register |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| tx_push | input | 1 | Push strobe, transmit queue |
| tx_wdata | input | 8 | Byte to push, transmit queue |
| tx_pop | input | 1 | Pop strobe, transmit queue |
| tx_rdata | output | 8 | Last byte popped, transmit queue |
| tx_count | output | 5 | Transmit occupancy |
| tx_room_flag | output | 1 | Transmit free-slot threshold reached |
| tx_overflow | output | 1 | Sticky: push to full transmit queue |
| tx_underflow | output | 1 | Sticky: pop from empty transmit queue |
| rx_push | input | 1 | Push strobe, receive queue |
| rx_wdata | input | 8 | Byte to push, receive queue |
| rx_pop | input | 1 | Pop strobe, receive queue |
| rx_rdata | output | 8 | Last byte popped, receive queue |
| rx_count | output | 5 | Receive occupancy |
| rx_full_flag | output | 1 | Receive level threshold reached |
| rx_overflow | output | 1 | Sticky: push to full receive queue |
| rx_underflow | output | 1 | Sticky: pop from empty receive queue |
| loopback_en | output | 1 | Loopback enable (bit 0) |
| modem_ctl_en | output | 1 | Modem-control enable (bit 3) |

## Verification
The boundary assertions for full and empty queues only claim something in cycles with no opposing strobe. A push into a full queue is checked only when no pop is present, and a pop from an empty queue only when no push is present. The stimulus keeps to this by never pairing push and pop at either end. The flag assertions assume the strobes are single-cycle levels sampled at the rising edge. The bench drives them one time unit after each edge. It sweeps every threshold code across every occupancy from 0 to 16 in both directions, and walks all 256 register values.

// File: rtl/sft_pkg.sv
package sft_pkg;

  typedef struct packed {
    logic [1:0] rx_lvl;
    logic [1:0] tx_lvl;
    logic       modem;
    logic       tx_flush;
    logic       rx_flush;
    logic       loop;
  } sft_ctrl_t;

  function automatic int rx_level(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  function automatic int tx_free_need(input logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 12;
      2'd2:    return 14;
      default: return 15;
    endcase
  endfunction

endpackage

// File: rtl/sft_ctrl_reg.sv
module sft_ctrl_reg
  import sft_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      stby,
  input  logic      wr,
  input  logic [7:0] wdata,
  output sft_ctrl_t ctrl_q,
  output sft_ctrl_t ctrl_nxt
);

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (rst || stby) ctrl_nxt = '0;
    else if (wr)     ctrl_nxt = sft_ctrl_t'(wdata);
  end

  always_ff @(posedge clk) begin
    ctrl_q <= ctrl_nxt;
  end

  a_r1_write_lands: assert property (@(posedge clk) disable iff (rst)
    (wr && !stby) |=> (ctrl_q == $past(wdata)));

  a_r2_standby_clears: assert property (@(posedge clk) disable iff (rst)
    stby |=> (ctrl_q == '0));

endmodule

// File: rtl/sft_byte_fifo.sv
module sft_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    count,
  output logic [CW-1:0]    count_nxt,
  output logic             overflow,
  output logic             underflow
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             is_full, is_empty, push_ok, pop_ok;

  assign is_full  = (count == FULL_CNT);
  assign is_empty = (count == '0);
  assign push_ok  = push && !flush && !is_full;
  assign pop_ok   = pop  && !flush && !is_empty;

  always_comb begin
    if (rst || flush) count_nxt = '0;
    else              count_nxt = count + CW'(push_ok) - CW'(pop_ok);
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (pop_ok) rdata <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    count <= count_nxt;
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (push && is_full)  overflow  <= 1'b1;
      if (pop  && is_empty) underflow <= 1'b1;
    end
  end

  a_r3_count_bounded: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);

  a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!flush && !push && !pop) |=> $stable(count));

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0 && !overflow && !underflow));

  a_r8_full_push_refused: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !flush && is_full) |=> (count == FULL_CNT && overflow));

  a_r9_empty_pop_refused: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && !flush && is_empty) |=> (count == '0 && underflow));

endmodule

// File: rtl/sft_level_flags.sv
module sft_level_flags
  import sft_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  sft_ctrl_t     ctrl_nxt,
  input  logic [CW-1:0] rx_cnt_nxt,
  input  logic [CW-1:0] tx_cnt_nxt,
  output logic          rx_flag,
  output logic          tx_flag
);

  logic rx_hit, tx_hit;

  assign rx_hit = int'(rx_cnt_nxt) >= rx_level(ctrl_nxt.rx_lvl);
  assign tx_hit = (DEPTH - int'(tx_cnt_nxt)) >= tx_free_need(ctrl_nxt.tx_lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_flag <= 1'b0;
      tx_flag <= 1'b1;
    end else begin
      rx_flag <= rx_hit;
      tx_flag <= tx_hit;
    end
  end

endmodule

// File: rtl/sft_trigger_ctrl.sv
module sft_trigger_ctrl
  import sft_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stby,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             tx_push,
  input  logic [WIDTH-1:0] tx_wdata,
  input  logic             tx_pop,
  output logic [WIDTH-1:0] tx_rdata,
  output logic [CW-1:0]    tx_count,
  output logic             tx_room_flag,
  output logic             tx_overflow,
  output logic             tx_underflow,
  input  logic             rx_push,
  input  logic [WIDTH-1:0] rx_wdata,
  input  logic             rx_pop,
  output logic [WIDTH-1:0] rx_rdata,
  output logic [CW-1:0]    rx_count,
  output logic             rx_full_flag,
  output logic             rx_overflow,
  output logic             rx_underflow,
  output logic             loopback_en,
  output logic             modem_ctl_en
);

  sft_ctrl_t     ctrl_q, ctrl_nxt;
  logic [CW-1:0] tx_cnt_nxt, rx_cnt_nxt;

  sft_ctrl_reg u_reg (
    .clk      (clk),
    .rst      (rst),
    .stby     (stby),
    .wr       (reg_wr),
    .wdata    (reg_wdata),
    .ctrl_q   (ctrl_q),
    .ctrl_nxt (ctrl_nxt)
  );

  sft_byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_tx_q (
    .clk       (clk),
    .rst       (rst),
    .flush     (ctrl_nxt.tx_flush),
    .push      (tx_push),
    .wdata     (tx_wdata),
    .pop       (tx_pop),
    .rdata     (tx_rdata),
    .count     (tx_count),
    .count_nxt (tx_cnt_nxt),
    .overflow  (tx_overflow),
    .underflow (tx_underflow)
  );

  sft_byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx_q (
    .clk       (clk),
    .rst       (rst),
    .flush     (ctrl_nxt.rx_flush),
    .push      (rx_push),
    .wdata     (rx_wdata),
    .pop       (rx_pop),
    .rdata     (rx_rdata),
    .count     (rx_count),
    .count_nxt (rx_cnt_nxt),
    .overflow  (rx_overflow),
    .underflow (rx_underflow)
  );

  sft_level_flags #(.DEPTH(DEPTH)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .ctrl_nxt   (ctrl_nxt),
    .rx_cnt_nxt (rx_cnt_nxt),
    .tx_cnt_nxt (tx_cnt_nxt),
    .rx_flag    (rx_full_flag),
    .tx_flag    (tx_room_flag)
  );

  assign reg_rdata    = ctrl_q;
  assign loopback_en  = ctrl_q.loop;
  assign modem_ctl_en = ctrl_q.modem;

  a_r4_rx_flag_level: assert property (@(posedge clk) disable iff (rst)
    rx_full_flag == (int'(rx_count) >= rx_level(reg_rdata[7:6])));

  a_r5_tx_flag_room: assert property (@(posedge clk) disable iff (rst)
    tx_room_flag == ((DEPTH - int'(tx_count)) >= tx_free_need(reg_rdata[5:4])));

  a_r7_tx_held_empty: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[2] |-> (tx_count == '0));

  a_r7_rx_held_empty: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[1] |-> (rx_count == '0));

endmodule

// File: tb/tb_sft_trigger_ctrl.sv
module tb_sft_trigger_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stby = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0] tx_wdata = '0, rx_wdata = '0, tx_rdata, rx_rdata;
  logic [4:0] tx_count, rx_count;
  logic       tx_room_flag, tx_overflow, tx_underflow;
  logic       rx_full_flag, rx_overflow, rx_underflow;
  logic       loopback_en, modem_ctl_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sft_trigger_ctrl dut (
    .clk(clk), .rst(rst), .stby(stby),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
    .tx_count(tx_count), .tx_room_flag(tx_room_flag),
    .tx_overflow(tx_overflow), .tx_underflow(tx_underflow),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .rx_count(rx_count), .rx_full_flag(rx_full_flag),
    .rx_overflow(rx_overflow), .rx_underflow(rx_underflow),
    .loopback_en(loopback_en), .modem_ctl_en(modem_ctl_en)
  );

  function automatic int rx_need(input int code);
    return (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 14;
  endfunction

  function automatic int tx_need(input int code);
    return 16 - (8 >> code);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    tick();
    reg_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 / R5 reset state
    check(reg_rdata == 8'h00, "R1 reset reg", reg_rdata, 0);
    check(tx_count == 0 && rx_count == 0, "R3 reset counts", tx_count + rx_count, 0);
    check(tx_room_flag == 1'b1, "R5 reset tx flag", tx_room_flag, 1);
    check(rx_full_flag == 1'b0, "R4 reset rx flag", rx_full_flag, 0);

    // R1 / R10 register sweep
    for (int v = 0; v < 256; v++) begin
      wr_ctrl(8'(v));
      check(reg_rdata == 8'(v), "R1 reg write", reg_rdata, v);
      check(loopback_en == v[0] && modem_ctl_en == v[3], "R10 mirrors",
            {modem_ctl_en, loopback_en}, {v[3], v[0]});
    end

    // R2 standby beats write
    wr_ctrl(8'hA5);
    stby = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h3C;
    tick();
    stby = 1'b0; reg_wr = 1'b0;
    check(reg_rdata == 8'h00, "R2 standby clear", reg_rdata, 0);

    // R4 / R3 / R8 / R9 receive sweep
    for (int e = 0; e < 4; e++) begin
      wr_ctrl(8'(e << 6));
      for (int i = 1; i <= 16; i++) begin
        rx_push = 1'b1; rx_wdata = 8'(e * 16 + i);
        tick();
        rx_push = 1'b0;
        check(rx_count == 5'(i), "R3 rx count up", rx_count, i);
        check(rx_full_flag == (i >= rx_need(e)), "R4 rx flag fill", rx_full_flag, int'(i >= rx_need(e)));
      end
      rx_push = 1'b1; rx_wdata = 8'hEE;
      tick();
      rx_push = 1'b0;
      check(rx_count == 16 && rx_overflow, "R8 rx push full", {rx_overflow, rx_count}, 48);
      for (int k = 0; k < 16; k++) begin
        rx_pop = 1'b1;
        tick();
        rx_pop = 1'b0;
        check(rx_rdata == 8'(e * 16 + k + 1), "R3 rx order", rx_rdata, e * 16 + k + 1);
        check(rx_full_flag == ((15 - k) >= rx_need(e)), "R4 rx flag drain",
              rx_full_flag, int'((15 - k) >= rx_need(e)));
      end
      rx_pop = 1'b1;
      tick();
      rx_pop = 1'b0;
      check(rx_count == 0 && rx_underflow, "R9 rx pop empty", {rx_underflow, rx_count}, 32);
      wr_ctrl(8'((e << 6) | 2));
      check(!rx_overflow && !rx_underflow, "R7 rx flush clears sticky",
            {rx_overflow, rx_underflow}, 0);
    end

    // R5 / R3 / R8 / R9 transmit sweep
    for (int e = 0; e < 4; e++) begin
      wr_ctrl(8'(e << 4));
      check(tx_room_flag == 1'b1, "R5 tx flag empty", tx_room_flag, 1);
      for (int i = 1; i <= 16; i++) begin
        tx_push = 1'b1; tx_wdata = 8'(100 + e * 16 + i);
        tick();
        tx_push = 1'b0;
        check(tx_count == 5'(i), "R3 tx count up", tx_count, i);
        check(tx_room_flag == ((16 - i) >= tx_need(e)), "R5 tx flag fill",
              tx_room_flag, int'((16 - i) >= tx_need(e)));
      end
      tx_push = 1'b1;
      tick();
      tx_push = 1'b0;
      check(tx_count == 16 && tx_overflow, "R8 tx push full", {tx_overflow, tx_count}, 48);
      for (int k = 0; k < 16; k++) begin
        tx_pop = 1'b1;
        tick();
        tx_pop = 1'b0;
        check(tx_rdata == 8'(100 + e * 16 + k + 1), "R3 tx order", tx_rdata, 100 + e * 16 + k + 1);
        check(tx_room_flag == ((k + 1) >= tx_need(e)), "R5 tx flag drain",
              tx_room_flag, int'((k + 1) >= tx_need(e)));
      end
      tx_pop = 1'b1;
      tick();
      tx_pop = 1'b0;
      check(tx_count == 0 && tx_underflow, "R9 tx pop empty", {tx_underflow, tx_count}, 32);
      wr_ctrl(8'((e << 4) | 4));
      check(!tx_overflow && !tx_underflow, "R7 tx flush clears sticky",
            {tx_overflow, tx_underflow}, 0);
    end

    // R6 threshold change applies at the write edge
    wr_ctrl(8'h00);
    for (int i = 0; i < 5; i++) begin
      rx_push = 1'b1; rx_wdata = 8'(i);
      tick();
    end
    rx_push = 1'b0;
    check(rx_full_flag == 1'b1, "R6 rx flag code0 at 5", rx_full_flag, 1);
    wr_ctrl(8'hC0);
    check(rx_full_flag == 1'b0, "R6 rx flag code3 at 5", rx_full_flag, 0);
    wr_ctrl(8'h40);
    check(rx_full_flag == 1'b1, "R6 rx flag code1 at 5", rx_full_flag, 1);
    for (int i = 0; i < 3; i++) begin
      tx_push = 1'b1; tx_wdata = 8'(i);
      tick();
    end
    tx_push = 1'b0;
    wr_ctrl(8'h70);
    check(tx_room_flag == 1'b0, "R6 tx flag code3 at 3", tx_room_flag, 0);
    wr_ctrl(8'h50);
    check(tx_room_flag == 1'b1, "R6 tx flag code1 at 3", tx_room_flag, 1);

    // R7 transmit flush holds empty, receive untouched
    wr_ctrl(8'h44);
    check(tx_count == 0, "R7 tx flushed", tx_count, 0);
    tx_push = 1'b1; tx_wdata = 8'h77;
    tick(); tick();
    tx_push = 1'b0;
    check(tx_count == 0, "R7 tx push ignored while held", tx_count, 0);
    check(rx_count == 5, "R7 rx untouched", rx_count, 5);
    wr_ctrl(8'h40);
    tx_push = 1'b1; tx_wdata = 8'h5A;
    tick();
    tx_push = 1'b0;
    check(tx_count == 1, "R7 tx resumes", tx_count, 1);

    // R3 simultaneous push and pop
    tx_push = 1'b1; tx_pop = 1'b1; tx_wdata = 8'h6B;
    tick();
    tx_push = 1'b0; tx_pop = 1'b0;
    check(tx_count == 1, "R3 push+pop count", tx_count, 1);
    check(tx_rdata == 8'h5A, "R3 push+pop data", tx_rdata, 'h5A);
    tx_pop = 1'b1;
    tick();
    tx_pop = 1'b0;
    check(tx_rdata == 8'h6B, "R3 push+pop order", tx_rdata, 'h6B);

    // R7 receive flush
    wr_ctrl(8'h42);
    check(rx_count == 0 && rx_full_flag == 1'b0, "R7 rx flushed", rx_count, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule